// File: doc/BRIEF.md
# Signal-Engine Register Front End

This block sits between a simple host register bus and a fixed-function signal engine. It owns a run register that starts and stops the engine's periodic computation pass. It owns a 28-bit coefficient memory that the host loads through a two-stage write pipeline. It also owns a completion flag with a mask bit that together drive an active-low interrupt line. The arithmetic of the engine is not modelled. A pacing counter stands in for it and emits a one-cycle completion pulse once every `PERIOD_CYC` clock cycles while the engine runs.

The host loads coefficients while the engine is stopped or running. It pushes the last coefficient through the pipeline by writing it two more times. It reads back the memory to confirm the load, and then sets the run bit. Each finished pass raises the ready flag. If the mask allows, the flag pulls the interrupt low until the host writes a one to the flag to clear it.

Top module: `dsp_ctl_front`

## Requirements
- R1: The coefficient region spans host addresses 0x4380 to 0x43BE. A read there returns the stored 28-bit word zero-extended to 32 bits. A write to any address outside the region never enters the write pipeline.
- R2: A region write is committed to memory only at the second later region write; a read returns committed memory contents only, never a value still in the pipeline.
- R3: Writing the same region address two more times after a sequence of writes commits that last value.
- R4: The run register (address 0xE228, 16 bits) resets to 0. While its bit 0 is 0, no computation pass completes. Clearing the bit stops further completions.
- R5: After reset, every region word reads 0, the status register reads 0, and `irq_n` is high.
- R6: While running, a pass completes every `PERIOD_CYC` clock edges, counted from the edge that writes run bit 0 to 1. Each completion sets bit 17 of the status register (address 0xE502).
- R7: `irq_n` is low exactly while status bit 17 and bit 17 of the mask register (address 0xE50A) are both set.
- R8: A status write with bit 17 at 1 clears the ready flag. A status write with bit 17 at 0 leaves the flag unchanged.
- R9: When a completion and a clearing status write fall on the same edge, the ready flag stays set.
- R10: `host_rdata` is loaded at the edge that samples `host_rd` and holds until the next read. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 16 | Register address |
| host_wdata | input | 32 | Write data |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 32 | Registered read data |
| irq_n | output | 1 | Active-low completion interrupt |
| eng_running | output | 1 | High while the run bit is set |

## Verification
Two functions can land on the same edge: the pacing counter's completion pulse setting the ready flag, and a host write-one-to-clear of that flag. The bench counts edges from the run write, so it knows exactly which edge carries the third completion. It lines up a clearing status write on that edge. It then expects `irq_n` to stay low and status bit 17 to read back as set. A clear issued on a quiet edge is checked as the contrast case.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
   localparam int unsigned DEF_ADDR_W = 16;
   localparam int unsigned DEF_DATA_W = 32;
   localparam int unsigned DEF_RAM_W  = 28;

   // read-source decode
   typedef enum logic [2:0] {
      SRC_NONE = 3'd0,
      SRC_RAM  = 3'd1,
      SRC_RUN  = 3'd2,
      SRC_STAT = 3'd3,
      SRC_MASK = 3'd4
   } rd_src_e;
endpackage

// File: rtl/dcf_wr_pipe.sv
module dcf_wr_pipe #(
   parameter int unsigned IDX_W  = 6,
   parameter int unsigned RAM_W  = 28,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [IDX_W-1:0] push_idx,
   input  logic [RAM_W-1:0] push_dat,
   output logic             commit,
   output logic [IDX_W-1:0] commit_idx,
   output logic [RAM_W-1:0] commit_dat
);
   logic [STAGES-1:0] vld_q;
   logic [IDX_W-1:0]  idx_q [STAGES];
   logic [RAM_W-1:0]  dat_q [STAGES];

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q    <= '0;
               idx_q[0] <= '0;
               dat_q[0] <= '0;
            end else if (push) begin
               vld_q    <= 1'b1;
               idx_q[0] <= push_idx;
               dat_q[0] <= push_dat;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= '0;
               for (int s = 0; s < STAGES; s++) begin
                  idx_q[s] <= '0;
                  dat_q[s] <= '0;
               end
            end else if (push) begin
               vld_q    <= {vld_q[STAGES-2:0], 1'b1};
               idx_q[0] <= push_idx;
               dat_q[0] <= push_dat;
               for (int s = 1; s < STAGES; s++) begin
                  idx_q[s] <= idx_q[s-1];
                  dat_q[s] <= dat_q[s-1];
               end
            end
         end
      end
   endgenerate

   // the oldest entry leaves for memory when a new write arrives
   assign commit     = push & vld_q[STAGES-1];
   assign commit_idx = idx_q[STAGES-1];
   assign commit_dat = dat_q[STAGES-1];
endmodule

// File: rtl/dcf_data_ram.sv
module dcf_data_ram #(
   parameter int unsigned DEPTH = 63,
   parameter int unsigned IDX_W = 6,
   parameter int unsigned RAM_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [RAM_W-1:0] wdat,
   input  logic [IDX_W-1:0] ridx,
   output logic [RAM_W-1:0] rdat
);
   logic [RAM_W-1:0] word_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) word_q[i] <= '0;
      end else if (we) begin
         word_q[widx] <= wdat;
      end
   end

   assign rdat = word_q[ridx];
endmodule

// File: rtl/dcf_pacer.sv
module dcf_pacer #(
   parameter int unsigned PERIOD_CYC = 31250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_on,
   output logic done
);
   localparam int unsigned CNT_W = $clog2(PERIOD_CYC + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run_on)        cnt_q <= '0;
      else if (cnt_q == LAST)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   assign done = run_on && (cnt_q == LAST);
endmodule

// File: rtl/dcf_irq.sv
module dcf_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   input  logic clr,
   input  logic mask_bit,
   output logic flag,
   output logic irq_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag <= 1'b0;
      else if (done)  flag <= 1'b1;   // a new completion wins over a clear
      else if (clr)   flag <= 1'b0;
   end

   assign irq_n = ~(flag & mask_bit);
endmodule

// File: rtl/dsp_ctl_front.sv
module dsp_ctl_front
   import dcf_pkg::*;
#(
   parameter int unsigned ADDR_W     = DEF_ADDR_W,
   parameter int unsigned DATA_W     = DEF_DATA_W,
   parameter int unsigned RAM_W      = DEF_RAM_W,
   parameter int unsigned RUN_W      = 16,
   parameter int unsigned PIPE_DEPTH = 2,
   parameter int unsigned READY_BIT  = 17,
   parameter int unsigned PERIOD_CYC = 31250,
   parameter logic [ADDR_W-1:0] RAM_BASE  = 16'h4380,
   parameter logic [ADDR_W-1:0] RAM_LAST  = 16'h43BE,
   parameter logic [ADDR_W-1:0] RUN_ADDR  = 16'hE228,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hE502,
   parameter logic [ADDR_W-1:0] MASK_ADDR = 16'hE50A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_wr,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rdata,
   output logic              irq_n,
   output logic              eng_running
);
   localparam int unsigned DEPTH = int'(RAM_LAST - RAM_BASE) + 1;
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (RAM_LAST < RAM_BASE) begin : g_bad_range
         $error("coefficient region end lies below its base");
      end
      if (RAM_W > DATA_W) begin : g_bad_width
         $error("memory word wider than the host bus");
      end
      if (READY_BIT >= DATA_W || RUN_W > DATA_W) begin : g_bad_field
         $error("status or run field outside the host bus");
      end
      if (PIPE_DEPTH < 1 || PERIOD_CYC < 2) begin : g_bad_timing
         $error("pipeline depth or pass period too small");
      end
   endgenerate

   // address decode
   logic              ram_hit;
   logic [ADDR_W-1:0] ram_off;
   logic [IDX_W-1:0]  ram_idx;
   rd_src_e           src;

   assign ram_hit = (host_addr >= RAM_BASE) && (host_addr <= RAM_LAST);
   assign ram_off = host_addr - RAM_BASE;
   assign ram_idx = ram_off[IDX_W-1:0];

   always_comb begin
      if (ram_hit)                     src = SRC_RAM;
      else if (host_addr == RUN_ADDR)  src = SRC_RUN;
      else if (host_addr == STAT_ADDR) src = SRC_STAT;
      else if (host_addr == MASK_ADDR) src = SRC_MASK;
      else                             src = SRC_NONE;
   end

   // control registers
   logic [RUN_W-1:0]  run_q;
   logic [DATA_W-1:0] mask_q;
   logic              run_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         mask_q <= '0;
      end else if (host_wr) begin
         if (src == SRC_RUN)  run_q  <= host_wdata[RUN_W-1:0];
         if (src == SRC_MASK) mask_q <= host_wdata;
      end
   end

   assign run_on      = run_q[0];
   assign eng_running = run_on;

   // coefficient write path
   logic             commit_en;
   logic [IDX_W-1:0] commit_idx;
   logic [RAM_W-1:0] commit_dat;
   logic [RAM_W-1:0] ram_rdat;

   dcf_wr_pipe #(.IDX_W(IDX_W), .RAM_W(RAM_W), .STAGES(PIPE_DEPTH)) u_pipe (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (host_wr && ram_hit),
      .push_idx   (ram_idx),
      .push_dat   (host_wdata[RAM_W-1:0]),
      .commit     (commit_en),
      .commit_idx (commit_idx),
      .commit_dat (commit_dat)
   );

   dcf_data_ram #(.DEPTH(DEPTH), .IDX_W(IDX_W), .RAM_W(RAM_W)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (commit_en),
      .widx  (commit_idx),
      .wdat  (commit_dat),
      .ridx  (ram_idx),
      .rdat  (ram_rdat)
   );

   // engine pacing and completion
   logic done_pulse;
   logic ready_q;
   logic clr_req;

   dcf_pacer #(.PERIOD_CYC(PERIOD_CYC)) u_pacer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_on (run_on),
      .done   (done_pulse)
   );

   assign clr_req = host_wr && (src == SRC_STAT) && host_wdata[READY_BIT];

   dcf_irq u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (done_pulse),
      .clr      (clr_req),
      .mask_bit (mask_q[READY_BIT]),
      .flag     (ready_q),
      .irq_n    (irq_n)
   );

   // registered read port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata <= '0;
      end else if (host_rd) begin
         unique case (src)
            SRC_RAM:  host_rdata <= DATA_W'(ram_rdat);
            SRC_RUN:  host_rdata <= DATA_W'(run_q);
            SRC_STAT: host_rdata <= DATA_W'(ready_q) << READY_BIT;
            SRC_MASK: host_rdata <= mask_q;
            default:  host_rdata <= '0;
         endcase
      end
   end
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned READY_BIT = 17,
   parameter logic [ADDR_W-1:0] RAM_BASE  = 16'h4380,
   parameter logic [ADDR_W-1:0] RAM_LAST  = 16'h43BE,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hE502
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] host_addr,
   input logic [DATA_W-1:0] host_wdata,
   input logic              host_wr,
   input logic              irq_n,
   input logic              run_on,
   input logic              done,
   input logic              flag,
   input logic              commit_en
);
   logic w1c, in_region;
   assign w1c       = host_wr && (host_addr == STAT_ADDR) && host_wdata[READY_BIT];
   assign in_region = (host_addr >= RAM_BASE) && (host_addr <= RAM_LAST);

   p_commit_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      commit_en |-> (host_wr && in_region));

   p_no_pass_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !run_on |-> !done);

   p_pass_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> flag);

   p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> flag);

   p_clear_drops_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c && !done) |=> !flag);

   p_flag_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!w1c && !done) |=> $stable(flag));

   p_collide_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c && done) |=> flag);
endmodule

bind dsp_ctl_front dcf_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .READY_BIT(READY_BIT),
   .RAM_BASE(RAM_BASE), .RAM_LAST(RAM_LAST), .STAT_ADDR(STAT_ADDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .host_wr    (host_wr),
   .irq_n      (irq_n),
   .run_on     (run_on),
   .done       (done_pulse),
   .flag       (ready_q),
   .commit_en  (commit_en)
);

// File: tb/tb_dsp_ctl_front.sv
module tb_dsp_ctl_front;
   localparam int P = 40;
   localparam logic [15:0] A_RUN = 16'hE228, A_STAT = 16'hE502, A_MASK = 16'hE50A;
   localparam logic [31:0] RDY = 32'h0002_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [31:0] host_rdata;
   logic        irq_n, eng_running;

   int cyc = 0, checks = 0, fails = 0, t_run = 0;
   logic rd_seen = 1'b0;

   typedef struct { string tag; logic [31:0] exp; } item_t;
   item_t sb_q[$];

   always #2 clk = ~clk;   // 250 MHz

   dsp_ctl_front #(.PERIOD_CYC(P)) dut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
      .irq_n(irq_n), .eng_running(eng_running));

   always @(posedge clk) begin
      cyc     <= cyc + 1;
      rd_seen <= host_rd;
   end

   // monitor: compare each read result against the queued expectation
   always @(negedge clk) begin
      if (rd_seen) begin
         checks++;
         if (sb_q.size() == 0) begin
            fails++;
            $display("FAIL scoreboard: read result with no expectation, got %h", host_rdata);
         end else begin
            item_t it;
            it = sb_q.pop_front();
            if (host_rdata !== it.exp) begin
               fails++;
               $display("FAIL %s: rdata=%h expected=%h", it.tag, host_rdata, it.exp);
            end
         end
      end
   end

   // all tasks start and end on a falling edge
   task automatic host_write(input logic [15:0] a, input logic [31:0] d);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(input logic [15:0] a, input logic [31:0] e, input string tag);
      item_t it;
      it.tag = tag; it.exp = e;
      sb_q.push_back(it);
      host_addr = a; host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic chk(input string tag, input logic act, input logic e);
      checks++;
      if (act !== e) begin
         fails++;
         $display("FAIL %s: got=%b expected=%b", tag, act, e);
      end
   endtask

   task automatic wait_until(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 reset state
      chk("R5 irq_n after reset", irq_n, 1'b1);
      host_read(16'h4380, 32'h0, "R5 first word zero");
      host_read(16'h43BE, 32'h0, "R5 last word zero");
      host_read(A_STAT, 32'h0, "R5 status zero");
      host_read(A_RUN, 32'h0, "R4 run reset value");

      // R2 pipeline: a value lands only at the second later write
      host_write(16'h4380, 32'h0AAA_0001);
      host_read(16'h4380, 32'h0, "R2 not committed after own write");
      host_write(16'h4381, 32'h0BBB_0002);
      host_read(16'h4380, 32'h0, "R2 not committed after one more write");
      host_write(16'h4382, 32'h0CCC_0003);
      host_read(16'h4380, 32'h0AAA_0001, "R2 committed after two more writes");
      host_read(16'h4381, 32'h0, "R2 second word still pending");
      host_read(16'h4380, 32'h0AAA_0001, "R10 read holds and does not advance");

      // R3 flush by repeating the last write
      host_write(16'h4382, 32'h0CCC_0003);
      host_read(16'h4381, 32'h0BBB_0002, "R3 middle word committed");
      host_read(16'h4382, 32'h0, "R3 last word after one repeat");
      host_write(16'h4382, 32'h0CCC_0003);
      host_read(16'h4382, 32'h0CCC_0003, "R3 last word after two repeats");

      // R1 width truncation and out-of-region writes
      host_write(16'h43BE, 32'hFFFF_FFFF);
      host_write(16'h43BE, 32'hFFFF_FFFF);
      host_write(16'h43BE, 32'hFFFF_FFFF);
      host_read(16'h43BE, 32'h0FFF_FFFF, "R1 28-bit word zero-extended");
      host_write(16'h4390, 32'h0123_4567);
      host_write(16'h43BF, 32'h0000_0011);
      host_write(16'h437F, 32'h0000_0022);
      host_read(16'h4390, 32'h0, "R1 outside writes do not push pipeline");
      host_read(16'h43BF, 32'h0, "R10 unmapped address reads zero");

      // R4 idle: nothing completes while run is 0
      host_write(A_MASK, RDY);
      wait_until(cyc + 3 * P);
      host_read(A_STAT, 32'h0, "R4 no completion while idle");
      chk("R4 irq_n high while idle", irq_n, 1'b1);

      // R6 first completion exactly P edges after the run write
      host_write(A_RUN, 32'h0000_0001);
      t_run = cyc;
      wait_until(t_run + P - 1);
      chk("R6 no completion one edge early", irq_n, 1'b1);
      @(negedge clk);
      chk("R6 R7 completion pulls irq_n low", irq_n, 1'b0);
      host_read(A_STAT, RDY, "R6 ready bit set");

      // R8 writing zero leaves the flag, writing one clears it
      host_write(A_STAT, 32'h0);
      chk("R8 zero write leaves irq_n low", irq_n, 1'b0);
      host_write(A_STAT, RDY);
      chk("R8 clear releases irq_n", irq_n, 1'b1);
      host_read(A_STAT, 32'h0, "R8 ready bit cleared");

      // R7 mask gates the interrupt but not the flag
      host_write(A_MASK, 32'h0);
      wait_until(t_run + 2 * P);
      chk("R7 masked flag leaves irq_n high", irq_n, 1'b1);
      host_read(A_STAT, RDY, "R6 second completion sets flag");
      host_write(A_MASK, RDY);
      chk("R7 unmasking pulls irq_n low", irq_n, 1'b0);
      host_write(A_STAT, RDY);
      chk("R8 clear before collision", irq_n, 1'b1);

      // R9 completion and clear on the same edge
      wait_until(t_run + 3 * P - 1);
      host_write(A_STAT, RDY);
      chk("R9 collision keeps irq_n low", irq_n, 1'b0);
      host_read(A_STAT, RDY, "R9 collision keeps ready bit");
      host_write(A_STAT, RDY);

      // R4 stop halts completions
      host_write(A_RUN, 32'h0);
      chk("R4 engine reported stopped", eng_running, 1'b0);
      wait_until(cyc + 3 * P);
      host_read(A_STAT, 32'h0, "R4 no completion after stop");
      chk("R4 irq_n high after stop", irq_n, 1'b1);
      host_read(A_RUN, 32'h0, "R4 run reads back zero");

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule